// File: doc/BRIEF.md
# Transaction Latency Sum and Min/Max Counter Pair

This block is a pair of performance registers that measure how long transactions take, in clock cycles. One register keeps a running total of the latency of every completed transaction of the chosen kind. The other packs the longest and the shortest single latency seen into one 32-bit word. A single selector register configures both. It names the latency class and, through a mask, one of six transaction sources. Each source delivers a one-cycle start strobe and a one-cycle end strobe.

A tracker holds one outstanding transaction at a time. It counts the cycles from start to end. On the end strobe it hands the latency to the accumulator, which adds it to the total and folds it into the packed extremes. Software reads and writes the selector and both result registers through a small register port. A second selector slot exists so that the pair fills two counter positions. That slot reads as zero and ignores writes.

Top module: `lat_pair_top`

## Requirements
- R1: After reset the selector reads 0, the total reads 0 and the packed register reads 0x0000FFFF (maximum 0 in bits 31:16, minimum 0xFFFF in bits 15:0).
- R2: Selector layout: bit 0 is a "no event" flag, bits 4:1 hold the class and bits 24:5 the event mask. Source k (0 interrupt, 1 data-cache read, 2 data-cache write, 3 instruction-cache read, 4 peripheral read, 5 peripheral write) is enabled by mask bit 5+2k. It is counted only when the class equals 5 and bit 0 is clear. Strobes of sources that are not enabled change nothing.
- R3: A start strobe sampled at clock edge t and an end strobe sampled at edge t+L (L ≥ 1) give latency L, and L is added (modulo 2^32) to the total at edge t+L.
- R4: At the same edge, the latency is clipped to 0xFFFF. Bits 31:16 take the larger of their value and the clipped latency, and bits 15:0 take the smaller.
- R5: Only one transaction is tracked at a time. A start while busy is ignored, and an end while idle is ignored. An end and a start at the same edge while busy completes the current transaction and begins a new one. An end and a start at the same edge while idle only begins one.
- R6: With several mask bits set, the strobes of all enabled sources form one merged stream. A start from one enabled source can be closed by an end from another.
- R7: Register addresses: 0 selector (bits 24:0 writable, upper bits read 0), 1 total, 2 packed min/max, 3 second selector (reads 0, writes ignored). Read data reflects the addressed register combinationally.
- R8: A write to the total or the packed register at the same edge as a completion stores the written value and discards that register's update. The other register still updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 6 | Per-source transaction start strobes |
| end_i | input | 6 | Per-source transaction end strobes |
| csr_we_i | input | 1 | Register write enable |
| csr_addr_i | input | 2 | Register address |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Register read data |

## Verification
Two pairs of events can land on one edge. The first is a transaction completing while software writes a result register. The bench raises the end strobe and the write enable in the same cycle, once for the total and once for the packed word, and expects the written value in the targeted register while the other still absorbs the latency. The second is an end strobe coinciding with a new start. This is provoked back to back, and both latencies must appear in the total and the extremes.

// File: rtl/lat_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the latency counter pair.
// Assumes a selector word whose class/mask layout is fixed by software.
package lat_pkg;
    localparam int unsigned SEL_W       = 25;
    localparam int unsigned NONE_BIT    = 0;
    localparam int unsigned CLASS_LSB   = 1;
    localparam int unsigned CLASS_W     = 4;
    localparam int unsigned MASK_BASE   = 5;
    localparam int unsigned MASK_STRIDE = 2;
    localparam logic [3:0]  LAT_CLASS   = 4'd5;

    typedef enum logic [1:0] {
        ADDR_SEL  = 2'd0,
        ADDR_SUM  = 2'd1,
        ADDR_MM   = 2'd2,
        ADDR_SEL2 = 2'd3
    } csr_addr_e;
endpackage

// File: rtl/lat_event_select.sv
`timescale 1ns/1ps
// Qualifies per-source strobes with the selector's enables, class and
// "no event" flag, then merges them into one start and one end strobe.
// Assumes strobes are single-cycle pulses synchronous to clk.
module lat_event_select #(
    parameter int unsigned NSRC = 6
) (
    input  logic [NSRC-1:0] en_i,
    input  logic [3:0]      class_i,
    input  logic            none_i,
    input  logic [NSRC-1:0] start_i,
    input  logic [NSRC-1:0] end_i,
    output logic            start_hit_o,
    output logic            end_hit_o
);
    import lat_pkg::*;

    logic active;

    // Merge enabled strobes when the latency class is selected.
    always_comb begin
        active      = (class_i == LAT_CLASS) && !none_i;
        start_hit_o = active && |(start_i & en_i);
        end_hit_o   = active && |(end_i & en_i);
    end
endmodule

// File: rtl/lat_tracker.sv
`timescale 1ns/1ps
// Tracks one outstanding transaction and measures its latency in cycles.
// Assumes merged start/end strobes; the cycle count saturates at all ones.
module lat_tracker #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_hit_i,
    input  logic             end_hit_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [CNT_W-1:0] lat_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Latency of a transaction ending this cycle, saturating.
    always_comb begin
        done_o = busy_o && end_hit_i;
        lat_o  = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;
    end

    // Busy flag and cycle counter: begin on start, close on end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_o) begin
            if (start_hit_i) begin
                busy_o <= 1'b1;
                cnt_q  <= '0;
            end
        end else if (end_hit_i) begin
            busy_o <= start_hit_i;
            cnt_q  <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/lat_accum.sv
`timescale 1ns/1ps
// Holds the latency total and the packed max/min word.
// Software writes take precedence over a same-cycle completion update.
module lat_accum #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] lat_i,
    input  logic              wr_sum_i,
    input  logic              wr_mm_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] sum_o,
    output logic [DATA_W-1:0] mm_o
);
    localparam int unsigned FIELD_W = DATA_W / 2;
    localparam logic [FIELD_W-1:0] FIELD_MAX = '1;

    logic [FIELD_W-1:0] lat_sat;
    logic [FIELD_W-1:0] max_nxt;
    logic [FIELD_W-1:0] min_nxt;

    // Clip the latency and compute the new extremes.
    always_comb begin
        lat_sat = (|lat_i[DATA_W-1:FIELD_W]) ? FIELD_MAX : lat_i[FIELD_W-1:0];
        max_nxt = (lat_sat > mm_o[DATA_W-1:FIELD_W]) ? lat_sat : mm_o[DATA_W-1:FIELD_W];
        min_nxt = (lat_sat < mm_o[FIELD_W-1:0]) ? lat_sat : mm_o[FIELD_W-1:0];
    end

    // Total register: write wins, otherwise accumulate on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_o <= '0;
        else if (wr_sum_i)
            sum_o <= wdata_i;
        else if (done_i)
            sum_o <= sum_o + lat_i;
    end

    // Packed extremes: write wins, otherwise fold in on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mm_o <= {{FIELD_W{1'b0}}, FIELD_MAX};
        else if (wr_mm_i)
            mm_o <= wdata_i;
        else if (done_i)
            mm_o <= {max_nxt, min_nxt};
    end
endmodule

// File: rtl/lat_pair_top.sv
`timescale 1ns/1ps
// Latency counter pair: selector register, source qualification,
// transaction tracker, accumulators and the register read/write port.
// Assumes DATA_W is even and at least the selector width.
module lat_pair_top #(
    parameter int unsigned NSRC   = 6,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   start_i,
    input  logic [NSRC-1:0]   end_i,
    input  logic              csr_we_i,
    input  logic [1:0]        csr_addr_i,
    input  logic [DATA_W-1:0] csr_wdata_i,
    output logic [DATA_W-1:0] csr_rdata_o
);
    import lat_pkg::*;

    logic [SEL_W-1:0]  sel_q;
    logic [NSRC-1:0]   src_en;
    logic              start_hit;
    logic              end_hit;
    logic              busy;
    logic              done;
    logic [DATA_W-1:0] lat;
    logic              wr_sum;
    logic              wr_mm;
    logic [DATA_W-1:0] sum_q;
    logic [DATA_W-1:0] mm_q;

    // Pick the enable bit of each source out of the mask field.
    for (genvar k = 0; k < NSRC; k++) begin : g_en
        assign src_en[k] = sel_q[MASK_BASE + MASK_STRIDE*k];
    end

    // Decode register writes to the result registers.
    always_comb begin
        wr_sum = csr_we_i && (csr_addr_i == ADDR_SUM);
        wr_mm  = csr_we_i && (csr_addr_i == ADDR_MM);
    end

    // Selector register; the second selector slot has no storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_q <= '0;
        else if (csr_we_i && csr_addr_i == ADDR_SEL)
            sel_q <= csr_wdata_i[SEL_W-1:0];
    end

    lat_event_select #(.NSRC(NSRC)) u_select (
        .en_i        (src_en),
        .class_i     (sel_q[CLASS_LSB +: CLASS_W]),
        .none_i      (sel_q[NONE_BIT]),
        .start_i     (start_i),
        .end_i       (end_i),
        .start_hit_o (start_hit),
        .end_hit_o   (end_hit)
    );

    lat_tracker #(.CNT_W(DATA_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_hit_i (start_hit),
        .end_hit_i   (end_hit),
        .busy_o      (busy),
        .done_o      (done),
        .lat_o       (lat)
    );

    lat_accum #(.DATA_W(DATA_W)) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .done_i   (done),
        .lat_i    (lat),
        .wr_sum_i (wr_sum),
        .wr_mm_i  (wr_mm),
        .wdata_i  (csr_wdata_i),
        .sum_o    (sum_q),
        .mm_o     (mm_q)
    );

    // Read multiplexer over the four register slots.
    always_comb begin
        unique case (csr_addr_i)
            ADDR_SEL: csr_rdata_o = {{(DATA_W-SEL_W){1'b0}}, sel_q};
            ADDR_SUM: csr_rdata_o = sum_q;
            ADDR_MM:  csr_rdata_o = mm_q;
            default:  csr_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/lat_pair_checker.sv
`timescale 1ns/1ps
// Temporal checks on the latency pair, bound to the top module.
module lat_pair_checker #(
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic [DATA_W-1:0] lat,
    input logic              wr_sum,
    input logic              wr_mm,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] sum_q,
    input logic [DATA_W-1:0] mm_q
);
    localparam int unsigned FW = DATA_W / 2;

    logic [FW-1:0] lat_clip;
    assign lat_clip = (lat > DATA_W'({FW{1'b1}})) ? {FW{1'b1}} : lat[FW-1:0];

    assert_sum_adds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_sum) |=> sum_q == $past(sum_q + lat));

    assert_sum_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !wr_sum) |=> $stable(sum_q));

    assert_max_covers_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_mm) |=> mm_q[DATA_W-1:FW] >= $past(lat_clip)
                          && mm_q[FW-1:0] <= $past(lat_clip));

    assert_mm_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !wr_mm) |=> $stable(mm_q));

    assert_sum_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sum |=> sum_q == $past(wdata));

    assert_mm_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mm |=> mm_q == $past(wdata));
endmodule

bind lat_pair_top lat_pair_checker #(.DATA_W(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done),
    .lat    (lat),
    .wr_sum (wr_sum),
    .wr_mm  (wr_mm),
    .wdata  (csr_wdata_i),
    .sum_q  (sum_q),
    .mm_q   (mm_q)
);

// File: tb/test_lat_pair_top.sv
`timescale 1ns/1ps
// Self-checking bench: sweeps every source and several latencies,
// then the ordering and write-collision corner cases.
module test_lat_pair_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  start_i = '0;
    logic [5:0]  end_i = '0;
    logic        csr_we_i = 1'b0;
    logic [1:0]  csr_addr_i = '0;
    logic [31:0] csr_wdata_i = '0;
    logic [31:0] csr_rdata_o;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    logic [31:0] exp_sum = 0;
    logic [15:0] exp_max = 16'h0000;
    logic [15:0] exp_min = 16'hFFFF;

    always #2 clk = ~clk;

    lat_pair_top i_lat_pair_top (.*);

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        csr_addr_i = a;
        #0.5;
        d = csr_rdata_o;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = d;
        @(negedge clk);
        csr_we_i = 1'b0;
    endtask

    function automatic logic [31:0] sel_for(input int src);
        return (32'd5 << 1) | (32'd1 << (5 + 2*src));
    endfunction

    function automatic void model(input int unsigned l);
        logic [15:0] s;
        exp_sum = exp_sum + l;
        s = (l > 65535) ? 16'hFFFF : l[15:0];
        if (s > exp_max) exp_max = s;
        if (s < exp_min) exp_min = s;
    endfunction

    task automatic txn(input int s0, input int s1, input int unsigned l);
        @(negedge clk); start_i[s0] = 1'b1;
        @(negedge clk); start_i[s0] = 1'b0;
        repeat (l-1) @(negedge clk);
        end_i[s1] = 1'b1;
        @(negedge clk); end_i[s1] = 1'b0;
    endtask

    task automatic check_results(input string req);
        logic [31:0] d;
        rd(2'd1, d); check({req, " total"}, d, exp_sum);
        rd(2'd2, d); check({req, " minmax"}, d, {exp_max, exp_min});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        int lens [6] = '{1, 2, 3, 5, 8, 13};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(2'd0, d); check("R1 selector", d, 32'h0);
        check_results("R1");
        // R2 nothing counted while selector is zero
        txn(0, 0, 4); check_results("R2 unselected");

        // R3/R4 sweep over sources and lengths; R2 foreign sources ignored
        for (int s = 0; s < 6; s++) begin
            wr(2'd0, sel_for(s));
            for (int i = 0; i < 6; i++) begin
                txn(s, s, lens[i] + s);
                model(lens[i] + s);
                check_results("R3 R4 sweep");
            end
            txn((s+1) % 6, (s+1) % 6, 7);
            check_results("R2 foreign source");
        end

        // R2 wrong class and "no event" flag
        wr(2'd0, (32'd4 << 1) | (32'd1 << 5));
        txn(0, 0, 3); check_results("R2 wrong class");
        wr(2'd0, sel_for(0) | 32'd1);
        txn(0, 0, 3); check_results("R2 none flag");

        // R7 register map
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R7 selector mask", d, 32'h01FF_FFFF);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, d); check("R7 second selector", d, 32'h0);
        rd(2'd0, d); check("R7 selector untouched", d, 32'h01FF_FFFF);

        // R6 merged stream: start on source 1, end on source 4
        wr(2'd0, sel_for(1) | sel_for(4));
        txn(1, 4, 9); model(9); check_results("R6 merged");

        // R5 end while idle ignored
        wr(2'd0, sel_for(2));
        @(negedge clk); end_i[2] = 1'b1;
        @(negedge clk); end_i[2] = 1'b0;
        check_results("R5 idle end");
        // R5 start while busy ignored: latency 6
        @(negedge clk); start_i[2] = 1'b1;
        @(negedge clk); start_i[2] = 1'b0;
        repeat (2) @(negedge clk); start_i[2] = 1'b1;
        @(negedge clk); start_i[2] = 1'b0;
        repeat (2) @(negedge clk); end_i[2] = 1'b1;
        @(negedge clk); end_i[2] = 1'b0;
        model(6); check_results("R5 busy start");
        // R5 back-to-back: latencies 3 then 2
        @(negedge clk); start_i[2] = 1'b1;
        @(negedge clk); start_i[2] = 1'b0;
        repeat (2) @(negedge clk); start_i[2] = 1'b1; end_i[2] = 1'b1;
        @(negedge clk); start_i[2] = 1'b0; end_i[2] = 1'b0;
        @(negedge clk); end_i[2] = 1'b1;
        @(negedge clk); end_i[2] = 1'b0;
        model(3); model(2); check_results("R5 back-to-back");
        // R5 start and end together while idle: start only, then latency 4
        @(negedge clk); start_i[2] = 1'b1; end_i[2] = 1'b1;
        @(negedge clk); start_i[2] = 1'b0; end_i[2] = 1'b0;
        check_results("R5 idle start+end");
        repeat (3) @(negedge clk); end_i[2] = 1'b1;
        @(negedge clk); end_i[2] = 1'b0;
        model(4); check_results("R5 idle start+end close");

        // R8 write to total collides with completion (latency 4)
        @(negedge clk); start_i[2] = 1'b1;
        @(negedge clk); start_i[2] = 1'b0;
        repeat (3) @(negedge clk);
        end_i[2] = 1'b1; csr_we_i = 1'b1; csr_addr_i = 2'd1; csr_wdata_i = 32'h0000_1234;
        @(negedge clk); end_i[2] = 1'b0; csr_we_i = 1'b0;
        model(4); exp_sum = 32'h0000_1234; check_results("R8 total write");
        // R8 write to packed word collides with completion (latency 5)
        @(negedge clk); start_i[2] = 1'b1;
        @(negedge clk); start_i[2] = 1'b0;
        repeat (4) @(negedge clk);
        end_i[2] = 1'b1; csr_we_i = 1'b1; csr_addr_i = 2'd2; csr_wdata_i = 32'h0010_0008;
        @(negedge clk); end_i[2] = 1'b0; csr_we_i = 1'b0;
        exp_sum = exp_sum + 5; exp_max = 16'h0010; exp_min = 16'h0008;
        check_results("R8 minmax write");

        // R4 saturation of a very long transaction
        wr(2'd0, sel_for(5));
        txn(5, 5, 70000); model(70000); check_results("R4 saturation");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule